// File: doc/BRIEF.md
# Translation Table Update Engine

This block maintains a small DMA translation table held in registers. It accepts one maintenance command at a time through a valid/ready handshake. It reports completion with a one-cycle done pulse that carries a success or parameter-error status. There are four commands. One writes a single entry and one reads a single entry. One fills a run of consecutive entries with the same value. The last writes a run of entries whose values are fetched one by one from a list in system memory.

Every command carries a window identifier, a bus I/O address, an argument and a page count. The argument is the entry value for writes and fills, and the list address for list writes. The I/O address is aligned down to a page and then converted to a table index relative to the window's bus base. Multi-page commands advance one page per entry and stop at the first entry that falls outside the table. Every entry write produces a map or unmap event for downstream translation caches. A simple request/valid read port serves the list fetches.

Top module: `tte_update_engine`

## Requirements
- R1: A command whose window identifier has any of bits 63:32 set, or whose low 32 bits differ from parameter WIN_ID, completes with status 1 and writes nothing.
- R2: The I/O address is aligned down to 2^PAGE_SHIFT bytes. The entry index is (aligned address - BUS_OFFSET) >> PAGE_SHIFT, computed as a 64-bit unsigned value.
- R3: An entry access whose index is greater than or equal to ENTRIES fails with status 1. An address below BUS_OFFSET wraps to a large index and also fails.
- R4: Opcode 0 writes the argument into one entry. Opcode 1 reads one entry, and the value appears on rdata_o during the done pulse with status 0.
- R5: Opcode 2 (fill) with a page count above ENTRIES completes with status 1 and no writes. Otherwise it writes the argument into that many consecutive pages.
- R6: Opcode 3 (list) completes with status 1 and issues no memory read when the page count exceeds 512 or any of bits 11:0 of the list address are set.
- R7: List entry i is read from list address + 8*i. mem_rdata_i bits 8k+7:8k hold the byte at address + k, and the byte at the lowest address becomes bits 63:56 of the entry.
- R8: A fill or list command stops at the first out-of-range entry with status 1. Entries before it stay written and entries after it are not touched.
- R9: A fill or list command with a page count of zero completes with status 1 and writes nothing.
- R10: Each entry write raises evt_valid_o for one cycle. The event carries iova = aligned address - BUS_OFFSET, xlat = value with the low PAGE_SHIFT bits cleared, mask = 2^PAGE_SHIFT - 1, perm = value bits 1:0, and unmap = 1 exactly when perm is 0.
- R11: Reset clears every entry to zero.
- R12: cmd_ready_o is high only while idle. Each accepted command produces exactly one done pulse, with status 0 for success and 1 for parameter error. No event follows it before the next command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command valid |
| cmd_ready_o | output | 1 | Engine idle, command accepted when valid |
| cmd_op_i | input | 2 | 0 write, 1 read, 2 fill, 3 list write |
| cmd_win_i | input | 64 | Window identifier |
| cmd_ioba_i | input | 64 | Bus I/O address of the first page |
| cmd_arg_i | input | 64 | Entry value, or list address for opcode 3 |
| cmd_pages_i | input | CNT_W | Page count for opcodes 2 and 3 |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 1 | 0 success, 1 parameter error, valid with done_o |
| rdata_o | output | 64 | Entry read by opcode 1, valid with done_o |
| mem_req_o | output | 1 | List fetch request, held until mem_rvalid_i |
| mem_addr_o | output | 64 | List fetch byte address |
| mem_rvalid_i | input | 1 | Fetch data valid |
| mem_rdata_i | input | 64 | Fetch data, byte k at bits 8k+7:8k |
| evt_valid_o | output | 1 | Entry write event |
| evt_iova_o | output | 64 | Page base within the window |
| evt_xlat_o | output | 64 | Page-masked translated address |
| evt_mask_o | output | 64 | Offset mask within a page |
| evt_perm_o | output | 2 | Permission bits of the written value |
| evt_unmap_o | output | 1 | 1 for an unmap event, 0 for a map event |

## Verification
The write event of the last entry of a command is registered on the same edge that moves the engine to completion, so the event and the done pulse share one cycle. The bench provokes this with every successful write, fill and list command. It waits one more cycle after done before it compares the collected event list, in order, against its own model. The second coincidence is a fetch response for a list entry whose index is out of range. That response must count as a fetch, produce no write, and end the command with an error. Runs that overrun the table end of a fill and of a list provoke it, and the bench judges it by the fetch count, the event count and a final read-back of all entries.

// File: rtl/tte_pkg.sv
package tte_pkg;

  localparam int unsigned TTE_W = 64;

  typedef enum logic [1:0] {
    OP_PUT  = 2'd0,
    OP_GET  = 2'd1,
    OP_FILL = 2'd2,
    OP_LIST = 2'd3
  } tte_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_FETCH,
    ST_DONE
  } tte_state_e;

  // lowest-address byte (bus bits 7:0) becomes the most significant byte
  function automatic logic [TTE_W-1:0] be_word(input logic [TTE_W-1:0] raw);
    logic [TTE_W-1:0] w;
    for (int k = 0; k < TTE_W / 8; k++) begin
      w[TTE_W-1-8*k -: 8] = raw[8*k +: 8];
    end
    return w;
  endfunction

endpackage

// File: rtl/tte_index_calc.sv
module tte_index_calc #(
  parameter int unsigned   ENTRIES    = 16,
  parameter int unsigned   PAGE_SHIFT = 12,
  parameter logic [63:0]   BUS_OFFSET = 64'h1_0000,
  parameter int unsigned   IDX_W      = 4
) (
  input  logic [63:0]      ioba_i,
  output logic [63:0]      rel_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             ok_o
);
  localparam logic [63:0] PG_LOW = (64'd1 << PAGE_SHIFT) - 64'd1;

  logic [63:0] full_idx;

  assign rel_o    = (ioba_i & ~PG_LOW) - BUS_OFFSET;
  assign full_idx = rel_o >> PAGE_SHIFT;
  assign ok_o     = full_idx < 64'(ENTRIES);
  assign idx_o    = full_idx[IDX_W-1:0];

endmodule

// File: rtl/tte_entry_store.sv
module tte_entry_store #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned IDX_W   = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [63:0]      wr_data_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [63:0]      rd_data_o
);
  logic [63:0] ent_q [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   ent_q[g] <= '0;
      else if (wr_en_i && wr_idx_i == IDX_W'(g))     ent_q[g] <= wr_data_i;
    end
  end

  assign rd_data_o = ent_q[rd_idx_i];

endmodule

// File: rtl/tte_event_gen.sv
module tte_event_gen #(
  parameter int unsigned PAGE_SHIFT = 12
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [63:0] iova_i,
  input  logic [63:0] val_i,
  output logic        evt_valid_o,
  output logic [63:0] evt_iova_o,
  output logic [63:0] evt_xlat_o,
  output logic [63:0] evt_mask_o,
  output logic [1:0]  evt_perm_o,
  output logic        evt_unmap_o
);
  localparam logic [63:0] PG_LOW = (64'd1 << PAGE_SHIFT) - 64'd1;

  logic        vld_q;
  logic [63:0] iova_q, val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      iova_q <= '0;
      val_q  <= '0;
    end else begin
      vld_q <= wr_en_i;
      if (wr_en_i) begin
        iova_q <= iova_i;
        val_q  <= val_i;
      end
    end
  end

  assign evt_valid_o = vld_q;
  assign evt_iova_o  = iova_q;
  assign evt_xlat_o  = val_q & ~PG_LOW;
  assign evt_mask_o  = PG_LOW;
  assign evt_perm_o  = val_q[1:0];
  assign evt_unmap_o = ~|val_q[1:0];

endmodule

// File: rtl/tte_update_engine.sv
module tte_update_engine
  import tte_pkg::*;
#(
  parameter int unsigned ENTRIES    = 16,
  parameter int unsigned PAGE_SHIFT = 12,
  parameter logic [63:0] BUS_OFFSET = 64'h1_0000,
  parameter logic [31:0] WIN_ID     = 32'h0000_0A05,
  parameter int unsigned LIST_MAX   = 512,
  parameter int unsigned LIST_ALIGN = 12,
  parameter int unsigned CNT_W      = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  output logic             cmd_ready_o,
  input  logic [1:0]       cmd_op_i,
  input  logic [63:0]      cmd_win_i,
  input  logic [63:0]      cmd_ioba_i,
  input  logic [63:0]      cmd_arg_i,
  input  logic [CNT_W-1:0] cmd_pages_i,
  output logic             done_o,
  output logic             status_o,
  output logic [63:0]      rdata_o,
  output logic             mem_req_o,
  output logic [63:0]      mem_addr_o,
  input  logic             mem_rvalid_i,
  input  logic [63:0]      mem_rdata_i,
  output logic             evt_valid_o,
  output logic [63:0]      evt_iova_o,
  output logic [63:0]      evt_xlat_o,
  output logic [63:0]      evt_mask_o,
  output logic [1:0]       evt_perm_o,
  output logic             evt_unmap_o
);
  localparam int unsigned IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [63:0] PG_SIZE = 64'd1 << PAGE_SHIFT;
  localparam logic [63:0] STRIDE  = 64'(TTE_W / 8);

  tte_state_e       state_q;
  tte_op_e          op_q, op_in;
  logic [63:0]      ioba_q, arg_q, rdata_q;
  logic [CNT_W-1:0] remain_q;
  logic             status_q;

  logic [63:0]      pages64, rel, rd_data, step_val;
  logic [IDX_W-1:0] idx;
  logic             idx_ok, accept, multi, pre_err, step_go, wr_en;

  assign op_in   = tte_op_e'(cmd_op_i);
  assign pages64 = 64'(cmd_pages_i);
  assign multi   = (op_in == OP_FILL) || (op_in == OP_LIST);
  assign accept  = cmd_valid_i && cmd_ready_o;

  always_comb begin
    pre_err = (|cmd_win_i[63:32]) || (cmd_win_i[31:0] != WIN_ID);
    if (multi && pages64 == '0)                                   pre_err = 1'b1;
    if (op_in == OP_FILL && pages64 > 64'(ENTRIES))               pre_err = 1'b1;
    if (op_in == OP_LIST && (pages64 > 64'(LIST_MAX) ||
                             |cmd_arg_i[LIST_ALIGN-1:0]))         pre_err = 1'b1;
  end

  assign step_go  = (state_q == ST_RUN) || (state_q == ST_FETCH && mem_rvalid_i);
  assign step_val = (state_q == ST_FETCH) ? be_word(mem_rdata_i) : arg_q;
  assign wr_en    = step_go && idx_ok && (op_q != OP_GET);

  tte_index_calc #(
    .ENTRIES(ENTRIES), .PAGE_SHIFT(PAGE_SHIFT), .BUS_OFFSET(BUS_OFFSET), .IDX_W(IDX_W)
  ) i_index (
    .ioba_i(ioba_q), .rel_o(rel), .idx_o(idx), .ok_o(idx_ok)
  );

  tte_entry_store #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) i_store (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_idx_i(idx), .wr_data_i(step_val),
    .rd_idx_i(idx), .rd_data_o(rd_data)
  );

  tte_event_gen #(.PAGE_SHIFT(PAGE_SHIFT)) i_event (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .iova_i(rel), .val_i(step_val),
    .evt_valid_o, .evt_iova_o, .evt_xlat_o, .evt_mask_o, .evt_perm_o, .evt_unmap_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      op_q     <= OP_PUT;
      ioba_q   <= '0;
      arg_q    <= '0;
      rdata_q  <= '0;
      remain_q <= '0;
      status_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          op_q     <= op_in;
          ioba_q   <= cmd_ioba_i;
          arg_q    <= cmd_arg_i;
          remain_q <= multi ? cmd_pages_i : CNT_W'(1);
          status_q <= pre_err;
          if (pre_err)                state_q <= ST_DONE;
          else if (op_in == OP_LIST)  state_q <= ST_FETCH;
          else                        state_q <= ST_RUN;
        end
        ST_RUN, ST_FETCH: if (step_go) begin
          if (!idx_ok) begin
            status_q <= 1'b1;
            state_q  <= ST_DONE;
          end else begin
            if (op_q == OP_GET)  rdata_q <= rd_data;
            if (op_q == OP_LIST) arg_q   <= arg_q + STRIDE;
            ioba_q   <= ioba_q + PG_SIZE;
            remain_q <= remain_q - CNT_W'(1);
            if (remain_q == CNT_W'(1)) begin
              status_q <= 1'b0;
              state_q  <= ST_DONE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cmd_ready_o = (state_q == ST_IDLE);
  assign done_o      = (state_q == ST_DONE);
  assign status_o    = status_q;
  assign rdata_o     = rdata_q;
  assign mem_req_o   = (state_q == ST_FETCH);
  assign mem_addr_o  = arg_q;

  a_r12_busy_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_ready_o) |=> !cmd_ready_o);
  a_r12_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r12_no_event_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_o |-> !cmd_ready_o);
  a_r7_fetch_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rvalid_i) |=> (mem_req_o && $stable(mem_addr_o)));
  a_r7_fetch_stride: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_rvalid_i) |=> (!mem_req_o || mem_addr_o == $past(mem_addr_o) + STRIDE));
  a_r6_list_start_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_req_o) |-> (mem_addr_o[LIST_ALIGN-1:0] == '0));

endmodule

// File: tb/test_tte_update_engine.sv
module test_tte_update_engine;

  localparam int          ENT  = 16;
  localparam int          PS   = 12;
  localparam logic [63:0] OFF  = 64'h1_0000;
  localparam logic [31:0] WIN  = 32'h0000_0A05;
  localparam logic [63:0] PG   = 64'd1 << PS;
  localparam logic [63:0] PGLO = PG - 64'd1;
  localparam logic [63:0] GOOD = {32'd0, WIN};

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_valid_i = 1'b0;
  logic        cmd_ready_o;
  logic [1:0]  cmd_op_i = '0;
  logic [63:0] cmd_win_i = '0, cmd_ioba_i = '0, cmd_arg_i = '0;
  logic [15:0] cmd_pages_i = '0;
  logic        done_o, status_o;
  logic [63:0] rdata_o;
  logic        mem_req_o;
  logic [63:0] mem_addr_o;
  logic        mem_rvalid_i = 1'b0;
  logic [63:0] mem_rdata_i = '0;
  logic        evt_valid_o, evt_unmap_o;
  logic [63:0] evt_iova_o, evt_xlat_o, evt_mask_o;
  logic [1:0]  evt_perm_o;

  always #2 clk = ~clk;

  tte_update_engine #(
    .ENTRIES(ENT), .PAGE_SHIFT(PS), .BUS_OFFSET(OFF), .WIN_ID(WIN),
    .LIST_MAX(512), .LIST_ALIGN(12), .CNT_W(16)
  ) i_tte_update_engine (
    .clk_i(clk), .rst_ni, .cmd_valid_i, .cmd_ready_o, .cmd_op_i, .cmd_win_i,
    .cmd_ioba_i, .cmd_arg_i, .cmd_pages_i, .done_o, .status_o, .rdata_o,
    .mem_req_o, .mem_addr_o, .mem_rvalid_i, .mem_rdata_i,
    .evt_valid_o, .evt_iova_o, .evt_xlat_o, .evt_mask_o, .evt_perm_o, .evt_unmap_o
  );

  int errors = 0, checks = 0;
  bit finished = 0;
  logic [63:0] exp_tbl [ENT];

  logic [63:0] ev_iova [32], ev_xlat [32], ev_mask [32];
  logic [1:0]  ev_perm [32];
  logic        ev_unmap [32];
  int ev_n = 0, fetch_n = 0;

  int          w_idx [32];
  logic [63:0] w_val [32], w_iova [32];
  int          wn, m_fetch;
  bit          m_err;
  logic [63:0] m_rdata;

  function automatic logic [7:0] mbyte(input logic [63:0] a);
    return a[7:0] ^ (a[15:8] * 8'd3) ^ 8'h5A;
  endfunction

  function automatic logic [63:0] mword(input logic [63:0] a);
    logic [63:0] w;
    for (int k = 0; k < 8; k++) w[63-8*k -: 8] = mbyte(a + 64'(k));
    return w;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // memory responder: one-cycle latency, byte k on bits 8k+7:8k
  initial forever begin
    @(negedge clk);
    if (mem_req_o && !mem_rvalid_i) begin
      mem_rvalid_i = 1'b1;
      for (int k = 0; k < 8; k++) mem_rdata_i[8*k +: 8] = mbyte(mem_addr_o + 64'(k));
      fetch_n++;
    end else begin
      mem_rvalid_i = 1'b0;
    end
  end

  initial forever begin
    @(negedge clk);
    if (evt_valid_o) begin
      if (ev_n < 32) begin
        ev_iova[ev_n] = evt_iova_o;  ev_xlat[ev_n] = evt_xlat_o;
        ev_mask[ev_n] = evt_mask_o;  ev_perm[ev_n] = evt_perm_o;
        ev_unmap[ev_n] = evt_unmap_o;
      end
      ev_n++;
    end
  end

  task automatic model(input logic [1:0] op, input logic [63:0] win, ioba, arg, input int n);
    int cnt;
    logic [63:0] a, rel, ix, v;
    m_err = 0; wn = 0; m_fetch = 0; m_rdata = '0;
    if (win[63:32] != 0 || win[31:0] != WIN)          m_err = 1;
    else if (op >= 2 && n == 0)                        m_err = 1;
    else if (op == 2 && n > ENT)                       m_err = 1;
    else if (op == 3 && (n > 512 || arg[11:0] != 0))   m_err = 1;
    else begin
      cnt = (op < 2) ? 1 : n;
      for (int i = 0; i < cnt; i++) begin
        a   = (ioba & ~PGLO) + 64'(i) * PG;
        rel = a - OFF;
        ix  = rel >> PS;
        v   = (op == 3) ? mword(arg + 64'(8 * i)) : arg;
        if (op == 3) m_fetch++;
        if (ix >= 64'(ENT)) begin m_err = 1; break; end
        if (op == 1) m_rdata = exp_tbl[ix];
        else begin
          w_idx[wn] = int'(ix); w_val[wn] = v; w_iova[wn] = rel; wn++;
        end
      end
    end
  endtask

  task automatic run(input string req, input logic [1:0] op, input logic [63:0] win,
                     input logic [63:0] ioba, input logic [63:0] arg, input int n);
    logic st;
    logic [63:0] rd;
    model(op, win, ioba, arg, n);
    @(negedge clk);
    ev_n = 0; fetch_n = 0;
    cmd_op_i = op; cmd_win_i = win; cmd_ioba_i = ioba; cmd_arg_i = arg;
    cmd_pages_i = 16'(n); cmd_valid_i = 1'b1;
    while (!cmd_ready_o) @(negedge clk);
    @(negedge clk);
    cmd_valid_i = 1'b0;
    chk(!cmd_ready_o, "R12", "ready while busy", 64'(cmd_ready_o), 64'd0);
    while (!done_o) @(negedge clk);
    st = status_o; rd = rdata_o;
    @(negedge clk);
    chk(!done_o, "R12", "done pulse width", 64'(done_o), 64'd0);
    chk(st == m_err, req, "status", 64'(st), 64'(m_err));
    if (op == 1 && !m_err) chk(rd == m_rdata, req, "read value", rd, m_rdata);
    chk(ev_n == wn, req, "event count", 64'(ev_n), 64'(wn));
    chk(fetch_n == m_fetch, req, "fetch count", 64'(fetch_n), 64'(m_fetch));
    for (int i = 0; i < wn && i < ev_n; i++) begin
      chk(ev_iova[i] == w_iova[i], "R10", "event iova", ev_iova[i], w_iova[i]);
      chk(ev_xlat[i] == (w_val[i] & ~PGLO), "R10", "event xlat", ev_xlat[i], w_val[i] & ~PGLO);
      chk(ev_mask[i] == PGLO, "R10", "event mask", ev_mask[i], PGLO);
      chk(ev_perm[i] == w_val[i][1:0], "R10", "event perm", 64'(ev_perm[i]), 64'(w_val[i][1:0]));
      chk(ev_unmap[i] == (w_val[i][1:0] == 2'b00), "R10", "event unmap",
          64'(ev_unmap[i]), 64'(w_val[i][1:0] == 2'b00));
    end
    for (int i = 0; i < wn; i++) exp_tbl[w_idx[i]] = w_val[i];
  endtask

  task automatic read_all(input string req);
    for (int i = 0; i < ENT; i++) run(req, 2'd1, GOOD, OFF + 64'(i) * PG, 64'd0, 1);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    for (int i = 0; i < ENT; i++) exp_tbl[i] = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R11: table reads back zero after reset
    read_all("R11");

    // R1: window identifier rejected
    run("R1", 2'd0, {32'h1, WIN}, OFF, 64'h1234_5003, 1);
    run("R1", 2'd0, GOOD ^ 64'h1, OFF, 64'h1234_5003, 1);
    run("R1", 2'd2, {32'h8000_0000, WIN}, OFF, 64'h7, 4);
    run("R1", 2'd1, GOOD + 64'h100, OFF, 64'h0, 1);

    // R2 R3 R4: single writes over unaligned addresses, below and beyond window
    for (int i = -1; i <= ENT; i++) begin
      logic [63:0] a = OFF + 64'(i) * PG + (64'(i * 291) & PGLO);
      run("R4", 2'd0, GOOD, a, {32'hCAFE_0000 + 32'(i), 20'h0, 10'(i * 7), 2'(i)}, 1);
    end
    run("R3", 2'd0, GOOD, OFF - 64'd1, 64'h3, 1);
    run("R2", 2'd1, GOOD, OFF + 5 * PG + PGLO, 64'h0, 1);
    read_all("R4");
    run("R3", 2'd1, GOOD, OFF + 64'(ENT) * PG, 64'h0, 1);

    // R9 R5 R8: fill
    run("R9", 2'd2, GOOD, OFF, 64'h5555_0001, 0);
    run("R5", 2'd2, GOOD, OFF, 64'h5555_0001, ENT + 1);
    run("R5", 2'd2, GOOD, OFF + 3 * PG + 64'h10, 64'hABCD_E002, 5);
    run("R5", 2'd2, GOOD, OFF, 64'h0000_9000, ENT);
    run("R8", 2'd2, GOOD, OFF + 10 * PG, 64'h7777_7003, 10);
    read_all("R8");

    // R9 R6 R7 R8: list write
    run("R9", 2'd3, GOOD, OFF, 64'h3000, 0);
    run("R6", 2'd3, GOOD, OFF, 64'h3000, 513);
    run("R6", 2'd3, GOOD, OFF, 64'h2008, 2);
    run("R6", 2'd3, GOOD, OFF, 64'h2800, 2);
    run("R7", 2'd3, GOOD, OFF + 2 * PG, 64'h3000, 6);
    run("R8", 2'd3, GOOD, OFF + 12 * PG, 64'h5000, 8);
    run("R8", 2'd3, GOOD, OFF, 64'h7000, 512);
    read_all("R7");

    // R11: reset after contents were written
    do_reset();
    read_all("R11");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule